// File: doc/BRIEF.md
# Entropy Output Buffer and Register File

This block sits on the bus side of a hardware random number generator. An upstream conditioning stage offers 128-bit conditioned batches through a valid/ready handshake. One batch is held in a staging register. Whenever the output FIFO is completely empty, the batch is moved into the FIFO as four 32-bit words, and a pulse asks upstream for a new conditioning round. Software sees three registers through a simple synchronous read/write port: control, status and data. Each read of the data register takes one word from the FIFO.

The block also tracks two fault conditions, which arrive as plain levels from health logic outside this block. The first is a seed (noise-source) fault. The second is a slow-clock fault, which software can mask. Each fault has a live current-status bit and a sticky event bit that software clears. The interrupt line is driven from the ready flag and the two sticky bits, gated by the enable bits.

Top module: `entropy_outbuf`

## Requirements
- R1: After reset, the control, status and data registers all read 0, `up_ready` is 1, and `irq` and `round_req` are 0.
- R2: The control register is at offset 0x0. Bit 2 is the generator enable and drives `noise_en`. Bit 3 is the interrupt enable. Bit 5 set means slow-clock detection is disabled. All other bits read 0.
- R3: A write to control bit 5 takes effect only while the generator enable is 0. While the generator is enabled the bit keeps its value; the enable and interrupt-enable bits still update.
- R4: `up_ready` is 1 exactly when the staging register is empty. A batch accepted with `up_valid` and `up_ready` both high fills the staging register, so `up_ready` is 0 in the next cycle.
- R5: When the FIFO is empty, the staging register is full and no seed fault is current, `round_req` is 1 for one cycle. At the next edge the four words enter the FIFO and the staging register empties.
- R6: The data register is at offset 0x8. Each read returns the next word, least significant 32 bits of the batch first, and removes that word. Read data appears on `bus_rdata` one cycle after the read.
- R7: A data read while the ready flag is 0 returns 0 and changes nothing.
- R8: The status register is at offset 0x4. Bit 0 is the ready flag. It is 1 from the batch transfer until the fourth word has been read, including while the generator is disabled.
- R9: Status bit 2 follows `seed_fault` and status bit 1 follows `clk_fault` masked by control bit 5. Each is registered once.
- R10: Status bits 6 (seed) and 5 (clock) are set when their current-status bit rises. Writing 0 to a bit clears it; writing 1 has no effect.
- R11: While status bit 2 is 1, no batch moves into the FIFO.
- R12: `irq` is 1 exactly when the generator enable and the interrupt enable are both 1 and the ready flag, status bit 5 or status bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream batch valid |
| up_data | input | 128 | Upstream conditioned batch |
| up_ready | output | 1 | Staging register empty |
| round_req | output | 1 | Batch transfer in progress; starts a new conditioning round |
| seed_fault | input | 1 | Seed fault level from the health tests |
| clk_fault | input | 1 | Slow-clock fault level from the clock checker |
| noise_en | output | 1 | Generator enable to the noise source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Register and fault results are due one cycle after their stimulus. A read strobe produces `bus_rdata` one edge later. A control or status write is visible to the next read. A change on `seed_fault` or `clk_fault` reaches status one edge later. A batch takes one edge to enter staging, where `round_req` and a low `up_ready` become visible. It takes a second edge to reach the FIFO, where the ready flag rises. The bench drives every input on a falling edge and samples on the following falling edge, so each check falls between the edge that produces the result and the next one. Where a result needs two edges, the bench waits one extra falling edge before it reads.

// File: rtl/ent_pkg.sv
package ent_pkg;
    localparam int unsigned ADDR_W = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_DATA = 4'h8;

    // control bit positions
    localparam int unsigned CB_EN  = 2;
    localparam int unsigned CB_IE  = 3;
    localparam int unsigned CB_CED = 5;

    // status bit positions
    localparam int unsigned SB_RDY  = 0;
    localparam int unsigned SB_CECS = 1;
    localparam int unsigned SB_SECS = 2;
    localparam int unsigned SB_CEIS = 5;
    localparam int unsigned SB_SEIS = 6;

    typedef struct packed {
        logic en;
        logic ie;
        logic ced;
        logic cecs;
        logic secs;
        logic ceis;
        logic seis;
    } csr_t;
endpackage

// File: rtl/ent_stage.sv
module ent_stage #(
    parameter int BATCH_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BATCH_W-1:0] in_data,
    output logic               in_ready,
    input  logic               take,
    output logic               full,
    output logic [BATCH_W-1:0] data
);
    typedef struct packed {
        logic               full;
        logic [BATCH_W-1:0] data;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (take) begin
            d.full = 1'b0;
        end else if (in_valid && !q.full) begin
            d.full = 1'b1;
            d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready = !q.full;
    assign full     = q.full;
    assign data     = q.data;
endmodule

// File: rtl/ent_fifo.sv
module ent_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stage_full,
    input  logic [WORD_W*DEPTH-1:0] stage_data,
    input  logic                    hold,
    input  logic                    pop,
    output logic                    take,
    output logic [WORD_W-1:0]       head,
    output logic                    nonempty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [PTR_W-1:0]             ptr;
        logic [DEPTH-1:0][WORD_W-1:0] mem;
    } st_t;

    st_t d, q;
    logic [WORD_W-1:0] lane [DEPTH];

    // slice the batch, lowest word first
    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        assign lane[g] = stage_data[g*WORD_W +: WORD_W];
    end

    assign take     = (q.cnt == '0) && stage_full && !hold;
    assign nonempty = (q.cnt != '0);
    assign head     = q.mem[q.ptr];

    always_comb begin
        d = q;
        if (take) begin
            for (int i = 0; i < DEPTH; i++) d.mem[i] = lane[i];
            d.cnt = CNT_W'(DEPTH);
            d.ptr = '0;
        end else if (pop && nonempty) begin
            d.cnt = q.cnt - 1'b1;
            d.ptr = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ent_csr.sv
module ent_csr import ent_pkg::*; #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [WORD_W-1:0] wdata,
    input  logic              seed_err,
    input  logic              clk_err,
    input  logic              drdy,
    output csr_t              regs,
    output logic              irq
);
    csr_t d, q;

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.en = wdata[CB_EN];
            d.ie = wdata[CB_IE];
            if (!q.en) d.ced = wdata[CB_CED];
        end
        d.cecs = clk_err & ~q.ced;
        d.secs = seed_err;
        if (wr_stat && !wdata[SB_CEIS]) d.ceis = 1'b0;
        if (wr_stat && !wdata[SB_SEIS]) d.seis = 1'b0;
        // a new event wins over a clear in the same cycle
        if (d.cecs && !q.cecs) d.ceis = 1'b1;
        if (d.secs && !q.secs) d.seis = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign regs = q;
    assign irq  = q.en & q.ie & (drdy | q.ceis | q.seis);
endmodule

// File: rtl/entropy_outbuf.sv
module entropy_outbuf import ent_pkg::*; #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up_valid,
    input  logic [WORD_W*DEPTH-1:0] up_data,
    output logic                    up_ready,
    output logic                    round_req,
    input  logic                    seed_fault,
    input  logic                    clk_fault,
    output logic                    noise_en,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata
    ,
    output logic                    irq
);
    localparam int BATCH_W = WORD_W * DEPTH;

    logic               stage_full;
    logic [BATCH_W-1:0] stage_data;
    logic               take;
    logic [WORD_W-1:0]  head;
    logic               drdy;
    logic               pop;
    csr_t               regs;
    logic [WORD_W-1:0]  ctrl_img, stat_img;
    logic [WORD_W-1:0]  rdata_d, rdata_q;

    assign pop = bus_rd && (bus_addr == OFF_DATA) && drdy;

    ent_stage #(.BATCH_W(BATCH_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(up_valid), .in_data(up_data), .in_ready(up_ready),
        .take(take), .full(stage_full), .data(stage_data)
    );

    ent_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .stage_full(stage_full), .stage_data(stage_data),
        .hold(regs.secs), .pop(pop),
        .take(take), .head(head), .nonempty(drdy)
    );

    ent_csr #(.WORD_W(WORD_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(bus_wr && (bus_addr == OFF_CTRL)),
        .wr_stat(bus_wr && (bus_addr == OFF_STAT)),
        .wdata(bus_wdata),
        .seed_err(seed_fault), .clk_err(clk_fault), .drdy(drdy),
        .regs(regs), .irq(irq)
    );

    always_comb begin
        ctrl_img          = '0;
        ctrl_img[CB_EN]   = regs.en;
        ctrl_img[CB_IE]   = regs.ie;
        ctrl_img[CB_CED]  = regs.ced;
        stat_img          = '0;
        stat_img[SB_RDY]  = drdy;
        stat_img[SB_CECS] = regs.cecs;
        stat_img[SB_SECS] = regs.secs;
        stat_img[SB_CEIS] = regs.ceis;
        stat_img[SB_SEIS] = regs.seis;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            case (bus_addr)
                OFF_CTRL: rdata_d = ctrl_img;
                OFF_STAT: rdata_d = stat_img;
                OFF_DATA: rdata_d = drdy ? head : '0;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign round_req = take;
    assign noise_en  = regs.en;
endmodule

// File: rtl/ent_chk.sv
module ent_chk import ent_pkg::*; #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              up_valid,
    input logic              up_ready,
    input logic              round_req,
    input logic              noise_en,
    input logic              irq,
    input logic              drdy,
    input logic              pop,
    input csr_t              csr
);
    p_ced_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        noise_en && bus_wr && bus_addr == OFF_CTRL |=> $stable(csr.ced));

    p_stage_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_ready |=> !up_ready);

    p_xfer_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        round_req |-> !drdy);

    p_xfer_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        round_req |=> drdy);

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == OFF_DATA && !drdy |=> bus_rdata == '0);

    p_rdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !pop |=> drdy);

    p_seis_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr.seis) |-> $rose(csr.secs));

    p_seed_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csr.secs |-> !round_req);

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_en |-> !irq);
endmodule

bind entropy_outbuf ent_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .up_valid(up_valid),
    .up_ready(up_ready), .round_req(round_req), .noise_en(noise_en),
    .irq(irq), .drdy(drdy), .pop(pop), .csr(regs)
);

// File: tb/sim_entropy_outbuf.sv
`timescale 1ns/1ps
module sim_entropy_outbuf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_valid = 1'b0;
    logic [127:0] up_data = '0;
    logic         up_ready, round_req, noise_en, irq;
    logic         seed_fault = 1'b0;
    logic         clk_fault = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    int           nchk = 0;
    int           nerr = 0;

    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;
    localparam logic [127:0] D1 = 128'hA1A1_0004_A1A1_0003_A1A1_0002_A1A1_0001;
    localparam logic [127:0] D2 = 128'hB2B2_1004_B2B2_1003_B2B2_1002_B2B2_1001;
    localparam logic [127:0] D3 = 128'hC3C3_2004_C3C3_2003_C3C3_2002_C3C3_2001;
    localparam logic [127:0] D4 = 128'hD4D4_3004_D4D4_3003_D4D4_3002_D4D4_3001;

    always #2.5 clk = ~clk;

    entropy_outbuf u0 (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready), .round_req(round_req), .seed_fault(seed_fault),
        .clk_fault(clk_fault), .noise_en(noise_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic push(input logic [127:0] v);
        @(negedge clk);
        up_valid = 1'b1; up_data = v;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [127:0] v);
        logic [31:0] got;
        for (int i = 0; i < 4; i++) begin
            rd(A_DATA, got);
            chk(req, got, v[i*32 +: 32]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] got;
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 up_ready", {31'b0, up_ready}, 32'h1);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 round_req", {31'b0, round_req}, 32'h0);
        rd(A_CTRL, got); chk("R1 ctrl", got, 32'h0);
        rd(A_STAT, got); chk("R1 stat", got, 32'h0);
        rd(A_DATA, got); chk("R1 data", got, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] got;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, got); chk("R2 ctrl bits", got, 32'h2C);
        chk("R2 noise_en", {31'b0, noise_en}, 32'h1);
        chk("R12 irq idle", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h0000_000C);
        rd(A_CTRL, got); chk("R3 ced locked", got, 32'h2C);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, got); chk("R3 ced locked on disable", got, 32'h20);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, got); chk("R3 ced free when off", got, 32'h0);
        chk("R2 noise_en off", {31'b0, noise_en}, 32'h0);
    endtask

    task automatic t_batch;
        logic [31:0] got;
        rd(A_DATA, got); chk("R7 empty read", got, 32'h0);
        push(D1);
        chk("R4 up_ready low", {31'b0, up_ready}, 32'h0);
        chk("R5 round_req", {31'b0, round_req}, 32'h1);
        @(negedge clk);
        chk("R5 up_ready back", {31'b0, up_ready}, 32'h1);
        rd(A_STAT, got); chk("R8 ready while disabled", got, 32'h1);
        push(D2);
        chk("R4 staged while full", {31'b0, up_ready}, 32'h0);
        chk("R5 no xfer while full", {31'b0, round_req}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(A_DATA, got);
            chk("R6 word order", got, D1[i*32 +: 32]);
            if (i == 2) begin
                rd(A_STAT, got); chk("R8 ready held", got, 32'h1);
            end
        end
        chk("R5 refill after drain", {31'b0, round_req}, 32'h1);
        rd(A_STAT, got); chk("R8 ready after refill", got, 32'h1);
        drain("R6 second batch", D2);
        rd(A_DATA, got); chk("R7 read past end", got, 32'h0);
        rd(A_STAT, got); chk("R8 ready cleared", got, 32'h0);
    endtask

    task automatic t_irq;
        wr(A_CTRL, 32'hC);
        chk("R12 irq no source", {31'b0, irq}, 32'h0);
        push(D3);
        @(negedge clk);
        chk("R12 irq on ready", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h8);
        chk("R12 irq gated by enable", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'hC);
        chk("R12 irq back", {31'b0, irq}, 32'h1);
        drain("R6 third batch", D3);
        chk("R12 irq after drain", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_seed;
        logic [31:0] got;
        @(negedge clk);
        seed_fault = 1'b1;
        push(D4);
        chk("R11 no xfer", {31'b0, round_req}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R11 stage kept", {31'b0, up_ready}, 32'h0);
        rd(A_STAT, got); chk("R9 R10 seed bits", got, 32'h44);
        chk("R12 irq on seed", {31'b0, irq}, 32'h1);
        rd(A_DATA, got); chk("R11 data zero", got, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, got); chk("R10 write one ignored", got, 32'h44);
        wr(A_STAT, 32'h0);
        rd(A_STAT, got); chk("R10 write zero clears", got, 32'h04);
        chk("R12 irq cleared", {31'b0, irq}, 32'h0);
        @(negedge clk);
        seed_fault = 1'b0;
        @(negedge clk);
        chk("R11 xfer resumes", {31'b0, round_req}, 32'h1);
        rd(A_STAT, got); chk("R9 seed cleared", got, 32'h01);
        drain("R6 fourth batch", D4);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_clock;
        logic [31:0] got;
        wr(A_CTRL, 32'h4);
        @(negedge clk);
        clk_fault = 1'b1;
        rd(A_STAT, got); chk("R9 R10 clock bits", got, 32'h22);
        wr(A_STAT, 32'h0);
        rd(A_STAT, got); chk("R10 clock cleared", got, 32'h02);
        @(negedge clk);
        clk_fault = 1'b0;
        rd(A_STAT, got); chk("R9 clock recovered", got, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h20);
        rd(A_CTRL, got); chk("R2 R3 ced set", got, 32'h20);
        @(negedge clk);
        clk_fault = 1'b1;
        rd(A_STAT, got); chk("R9 clock masked", got, 32'h0);
        clk_fault = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ctrl;
        t_batch;
        t_irq;
        t_seed;
        t_clock;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule